// File: doc/BRIEF.md
# Card Status Change Interrupt Unit

This block watches the status lines of a removable card and tells the host when any of them moves. The lines are two battery-condition inputs, two card-presence inputs, one ready/IRQ input and two voltage-sense inputs. Each line first passes through a two-flop synchroniser. The synchronised values can be read in a pin register. Any change of a synchronised line sets a sticky bit in a status-changed register. A main interrupt is raised while any sticky bit is also set in an enable mask. The host clears a sticky bit by writing one to it.

The ready/IRQ line has a second interrupt of its own, with four trigger modes. The two level modes follow the line. The two edge modes latch a pending flag until the host writes one to clear it. A programmable interrupt-level field is passed straight to an output, so the system can route the main interrupt. The host uses a simple register port: a 2-bit address, a write strobe, write data and combinational read data.

Two state machines control the timing. The warm-up machine steps WU_SYNC1 → WU_SYNC2 → WU_PRIME → WU_RUN, taking one transition per clock after reset, and stays in WU_RUN until the next reset. Change detection is armed only in WU_RUN, so the first samples after reset set nothing. The ready machine has two states. It moves RP_IDLE → RP_PEND on a qualifying edge in an edge mode. It moves RP_PEND → RP_IDLE when the host clears the flag with no new edge in the same cycle, or when a level mode is selected.

Top module: `card_evt_irq`

## Requirements
- R1: Address 0 reads the synchronised inputs within three clock edges of a change. The bit map is [1:0] battery, [3:2] card presence, [4] ready, [6:5] voltage sense, and bit 7 reads 0.
- R2: After warm-up, a change of any synchronised input sets the matching bit of the status-changed register (address 1, bits [6:0]). The bit stays set when the input changes back.
- R3: Writing address 1 clears each status-changed bit whose data bit is one. Data bits that are zero leave their status-changed bits unchanged.
- R4: If a change is detected in the same cycle as a write-one clear of that bit, the bit stays set.
- R5: `status_irq_o` is high exactly when the status-changed register AND the enable mask (address 2, bits [6:0]) is nonzero.
- R6: Address 3 bits [3:0] hold the interrupt level, which appears on `irq_level_o`.
- R7: Address 3 bits [5:4] select the ready trigger mode: 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. In the level modes, `ready_irq_o` follows the synchronised ready input, active low in mode 0 and active high in mode 1.
- R8: In an edge mode, a matching edge latches a pending flag. The flag drives `ready_irq_o`, reads at address 1 bit 7, and stays set until the host writes one to address 1 bit 7. An edge in the same cycle as the clear wins.
- R9: After reset all registers read zero, apart from the pin register. Warm-up lasts three clocks, and the samples taken during warm-up set no status-changed bits.
- R10: `ready_irq_o` is low while address 3 bit 6 (ready enable) is zero. Edges that occur while it is zero are not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| batt_ok_i | input | 2 | Battery-condition lines from the card |
| card_in_i | input | 2 | Card-presence lines |
| ready_i | input | 1 | Ready/IRQ line |
| volt_sense_i | input | 2 | Voltage-sense lines |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` (combinational) |
| status_irq_o | output | 1 | Main status-change interrupt |
| ready_irq_o | output | 1 | Ready/IRQ interrupt |
| irq_level_o | output | 4 | Programmed interrupt level |

## Verification
The assertions take for granted that the card lines are asynchronous but stay stable for at least a few clocks, so every move passes through the synchroniser as a clean change. They also take for granted that writes are single-cycle strobes. The stimulus changes a card line only after the previous change has had four or more clocks to settle, except in the clear-collision case. In that case the write is placed so that its edge meets the edge at which the synchronised change is detected. All stimulus changes are made just after a rising edge.

// File: rtl/cse_pkg.sv
package cse_pkg;
    localparam int unsigned N_PINS   = 7;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned LVL_W    = 4;
    localparam int unsigned RDY_BIT  = 4;
    localparam int unsigned MODE_LSB = 4;
    localparam int unsigned EN_BIT   = 6;
    localparam int unsigned PEND_BIT = 7;

    localparam logic [ADDR_W-1:0] A_PINS = 2'd0;
    localparam logic [ADDR_W-1:0] A_CHG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_ENA  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd3;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        WU_SYNC1 = 2'd0,
        WU_SYNC2 = 2'd1,
        WU_PRIME = 2'd2,
        WU_RUN   = 2'd3
    } wu_e;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_PEND = 1'b1
    } rp_e;
endpackage

// File: rtl/cse_sync.sv
module cse_sync #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q[i] <= 1'b0;
                stage2_q[i] <= 1'b0;
            end else begin
                stage1_q[i] <= async_i[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/cse_warmup.sv
module cse_warmup
    import cse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic armed_o
);
    wu_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WU_SYNC1;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WU_SYNC1: state_d = WU_SYNC2;
            WU_SYNC2: state_d = WU_PRIME;
            WU_PRIME: state_d = WU_RUN;
            WU_RUN:   state_d = WU_RUN;
        endcase
    end

    always_comb begin
        armed_o = (state_q == WU_RUN);
    end

    // R9
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> armed_o);
endmodule

// File: rtl/cse_ready_path.sv
module cse_ready_path
    import cse_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  armed_i,
    input  logic  en_i,
    input  trig_e mode_i,
    input  logic  rdy_now_i,
    input  logic  rdy_prev_i,
    input  logic  clr_i,
    output logic  irq_o,
    output logic  pend_o
);
    rp_e  state_q, state_d;
    logic edge_mode;
    logic hit;

    assign edge_mode = (mode_i == TRIG_FALL) || (mode_i == TRIG_RISE);

    always_comb begin
        hit = 1'b0;
        if (armed_i && en_i) begin
            unique case (mode_i)
                TRIG_RISE: hit = rdy_now_i && !rdy_prev_i;
                TRIG_FALL: hit = !rdy_now_i && rdy_prev_i;
                default:   hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: if (hit) state_d = RP_PEND;
            RP_PEND: begin
                if (!edge_mode)         state_d = RP_IDLE;
                else if (clr_i && !hit) state_d = RP_IDLE;
            end
        endcase
    end

    always_comb begin
        pend_o = (state_q == RP_PEND);
        irq_o  = 1'b0;
        if (en_i) begin
            unique case (mode_i)
                TRIG_LOW:  irq_o = !rdy_now_i;
                TRIG_HIGH: irq_o = rdy_now_i;
                default:   irq_o = pend_o;
            endcase
        end
    end

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && edge_mode && !clr_i) |=> pend_o);

    // R10
    no_capture_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !en_i) |=> !pend_o);
endmodule

// File: rtl/card_evt_irq.sv
module card_evt_irq
    import cse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        batt_ok_i,
    input  logic [1:0]        card_in_i,
    input  logic              ready_i,
    input  logic [1:0]        volt_sense_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              status_irq_o,
    output logic              ready_irq_o,
    output logic [LVL_W-1:0]  irq_level_o
);
    logic [N_PINS-1:0] pins_raw;
    logic [N_PINS-1:0] pins_s;
    logic [N_PINS-1:0] prev_q;
    logic [N_PINS-1:0] det;
    logic [N_PINS-1:0] chg_q;
    logic [N_PINS-1:0] ena_q;
    logic [N_PINS-1:0] clr_vec;
    logic [LVL_W-1:0]  lvl_q;
    trig_e             mode_q;
    logic              rdy_en_q;
    logic              armed;
    logic              wr_chg;
    logic              rdy_pend;

    assign pins_raw = {volt_sense_i, ready_i, card_in_i, batt_ok_i};

    cse_sync #(.W(N_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_s)
    );

    cse_warmup u_warm (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed_o (armed)
    );

    assign wr_chg  = wr_en_i && (addr_i == A_CHG);
    assign clr_vec = wr_chg ? wr_data_i[N_PINS-1:0] : '0;
    assign det     = armed ? (pins_s ^ prev_q) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            chg_q    <= '0;
            ena_q    <= '0;
            lvl_q    <= '0;
            mode_q   <= TRIG_LOW;
            rdy_en_q <= 1'b0;
        end else begin
            prev_q <= pins_s;
            chg_q  <= (chg_q & ~clr_vec) | det;
            if (wr_en_i && addr_i == A_ENA) ena_q <= wr_data_i[N_PINS-1:0];
            if (wr_en_i && addr_i == A_CTRL) begin
                lvl_q    <= wr_data_i[LVL_W-1:0];
                mode_q   <= trig_e'(wr_data_i[MODE_LSB+1:MODE_LSB]);
                rdy_en_q <= wr_data_i[EN_BIT];
            end
        end
    end

    cse_ready_path u_rdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed_i    (armed),
        .en_i       (rdy_en_q),
        .mode_i     (mode_q),
        .rdy_now_i  (pins_s[RDY_BIT]),
        .rdy_prev_i (prev_q[RDY_BIT]),
        .clr_i      (wr_chg && wr_data_i[PEND_BIT]),
        .irq_o      (ready_irq_o),
        .pend_o     (rdy_pend)
    );

    always_comb begin
        rd_data_o = '0;
        unique case (addr_i)
            A_PINS: rd_data_o[N_PINS-1:0] = pins_s;
            A_CHG: begin
                rd_data_o[N_PINS-1:0] = chg_q;
                rd_data_o[PEND_BIT]   = rdy_pend;
            end
            A_ENA:  rd_data_o[N_PINS-1:0] = ena_q;
            A_CTRL: begin
                rd_data_o[LVL_W-1:0]             = lvl_q;
                rd_data_o[MODE_LSB+1:MODE_LSB]   = mode_q;
                rd_data_o[EN_BIT]                = rdy_en_q;
            end
        endcase
    end

    assign status_irq_o = |(chg_q & ena_q);
    assign irq_level_o  = lvl_q;

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_chg |=> ((chg_q & $past(chg_q)) == $past(chg_q)));

    // R4
    clear_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_chg && det != '0) |=> ((chg_q & $past(det)) == $past(det)));

    // R9
    warm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (chg_q == '0));

    // R5
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |-> !status_irq_o);
endmodule

// File: tb/sim_card_evt_irq.sv
module sim_card_evt_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] batt_ok = 2'b01;
    logic [1:0] card_in = 2'b01;
    logic       ready = 1'b1;
    logic [1:0] volt = 2'b10;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       status_irq;
    logic       ready_irq;
    logic [3:0] irq_level;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    card_evt_irq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .batt_ok_i    (batt_ok),
        .card_in_i    (card_in),
        .ready_i      (ready),
        .volt_sense_i (volt),
        .addr_i       (addr),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .rd_data_o    (rd_data),
        .status_irq_o (status_irq),
        .ready_irq_o  (ready_irq),
        .irq_level_o  (irq_level)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        #3;
        rd(2'd1, v); chk("R9 reset chg", v, 8'h00);
        rd(2'd2, v); chk("R9 reset ena", v, 8'h00);
        rd(2'd3, v); chk("R9 reset ctrl", v, 8'h00);
        chk("R9 reset irqs", {6'd0, status_irq, ready_irq}, 8'h00);
        rst_n = 1'b1;
        tick(6);
        rd(2'd0, v); chk("R1 pins after warm-up", v, 8'h55);
        rd(2'd1, v); chk("R9 first sample sets nothing", v, 8'h00);
    endtask

    task automatic t_change();
        logic [7:0] v;
        card_in[0] = 1'b0;
        tick(4);
        rd(2'd1, v); chk("R2 change sets bit2", v, 8'h04);
        chk("R5 masked irq low", {7'd0, status_irq}, 8'h00);
        wr(2'd2, 8'h01);
        chk("R5 other enable irq low", {7'd0, status_irq}, 8'h00);
        wr(2'd2, 8'h04);
        chk("R5 enabled irq high", {7'd0, status_irq}, 8'h01);
        card_in[0] = 1'b1;
        tick(4);
        rd(2'd1, v); chk("R2 bit sticky after return", v, 8'h04);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R3 zero write ignored", v, 8'h04);
        wr(2'd1, 8'h04);
        rd(2'd1, v); chk("R3 write-one clears", v, 8'h00);
        chk("R5 irq drops after clear", {7'd0, status_irq}, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        volt[0] = 1'b1;
        tick(2);
        wr(2'd1, 8'h20);
        rd(2'd1, v); chk("R4 change beats clear", v, 8'h20);
        rd(2'd0, v); chk("R1 pins track", v, 8'h75);
        wr(2'd1, 8'h20);
        rd(2'd1, v); chk("R3 clear after collide", v, 8'h00);
    endtask

    task automatic t_level();
        wr(2'd3, 8'h0A);
        chk("R6 level out", {4'd0, irq_level}, 8'h0A);
    endtask

    task automatic t_ready_level();
        wr(2'd3, 8'h5A);
        chk("R7 high level", {7'd0, ready_irq}, 8'h01);
        wr(2'd3, 8'h4A);
        chk("R7 low level inactive", {7'd0, ready_irq}, 8'h00);
        ready = 1'b0;
        tick(3);
        chk("R7 low level active", {7'd0, ready_irq}, 8'h01);
        wr(2'd1, 8'h7F);
    endtask

    task automatic t_ready_edge();
        logic [7:0] v;
        wr(2'd3, 8'h7A);
        ready = 1'b1; tick(4);
        chk("R8 rise latched", {7'd0, ready_irq}, 8'h01);
        ready = 1'b0; tick(4);
        chk("R8 rise held", {7'd0, ready_irq}, 8'h01);
        rd(2'd1, v); chk("R8 pending bit7", v & 8'h80, 8'h80);
        wr(2'd1, 8'h80);
        chk("R8 cleared", {7'd0, ready_irq}, 8'h00);
        wr(2'd3, 8'h6A);
        ready = 1'b1; tick(4);
        chk("R8 fall ignores rise", {7'd0, ready_irq}, 8'h00);
        ready = 1'b0; tick(4);
        chk("R8 fall latched", {7'd0, ready_irq}, 8'h01);
        wr(2'd1, 8'hFF);
    endtask

    task automatic t_ready_disable();
        logic [7:0] v;
        wr(2'd3, 8'h3A);
        ready = 1'b1; tick(4);
        chk("R10 disabled no irq", {7'd0, ready_irq}, 8'h00);
        wr(2'd3, 8'h7A);
        tick();
        chk("R10 edge not kept", {7'd0, ready_irq}, 8'h00);
        rd(2'd1, v); chk("R10 no pending bit", v & 8'h80, 8'h00);
    endtask

    initial begin
        t_reset();
        t_change();
        t_clear();
        t_collide();
        t_level();
        t_ready_level();
        t_ready_edge();
        t_ready_disable();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule